// File: doc/BRIEF.md
# Half-Bridge Gate Pulse Generator

This block turns a digital sawtooth period counter into the two complementary gate enables of a half-bridge: a low-side enable and a high-side enable. Each switching period runs the low-side pulse first, then a dead gap, then the high-side pulse, then a second dead gap of the same length. The period comes from one of two parameters. The ignition period is the shorter one (higher switching frequency). The run period is the longer one. A mode input picks between them.

The dead-time count is an input and does not depend on the period. Two reduction inputs shorten the high-side pulse: a trim value from the current-limit logic and a soft-start cut from the burst logic. Whichever of the two is larger applies. The period does not change, so every count taken from the high side is added to the low side. A floor of one tenth of the period stops the high-side pulse from shrinking further. A gate-enable input from the burst dimming logic starts and stops switching. Each start, whether after reset or after the enable was low, opens with a low-side pulse so that the bootstrap supply is charged before the high-side switch turns on.

Top module: `hb_pulse_gen`

## Requirements
- R1: While switching, the outputs repeat with a period of P clocks. P is IGN_PERIOD when `mode_run`=0 (ignition) and RUN_PERIOD when `mode_run`=1 (run), where IGN_PERIOD < RUN_PERIOD.
- R2: Within a period, counting phases from 0: `lo_gate` is high for phases [0, L). Both outputs are low for D phases. `ho_gate` is high for the next H phases. Both outputs are low for the final D phases.
- R3: D equals `dead_cnt` clamped to the range [1, P/2 − ceil(P/10)]. D does not change with trim or soft-start inputs, and it is the same count in both modes.
- R4: H = max(P/2 − D − max(`duty_trim`, `ss_cut`), ceil(P/10)) and L = P − 2D − H (integer division). As a result, H never exceeds half the period minus the dead time.
- R5: The high-side pulse is never shorter than ceil(P/10) clocks, however large the trim or soft-start inputs are.
- R6: On the first output cycle after `gate_en` is sampled high while idle, `lo_gate` is high. `ho_gate` never rises before `lo_gate` has been high since the last start.
- R7: One clock after `gate_en` is sampled low, both outputs are low and stay low. A later enable restarts the period at phase 0.
- R8: `lo_gate` and `ho_gate` are never high in the same cycle. Neither output rises in the cycle directly after the other was high.
- R9: `mode_run`, `dead_cnt`, `duty_trim` and `ss_cut` are sampled only at a period boundary or while idle. A change in the middle of a period leaves the rest of that period unchanged.
- R10: The synchronous active-high reset `rst` drives both outputs low. After reset, switching restarts with the low-side pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_run | input | 1 | 0 selects the ignition period, 1 selects the run period |
| dead_cnt | input | DT_W | Requested dead time in clocks |
| duty_trim | input | TRIM_W | High-side reduction from the current limiter |
| ss_cut | input | TRIM_W | High-side reduction from soft start |
| gate_en | input | 1 | Switching enable from burst dimming |
| lo_gate | output | 1 | Low-side gate enable |
| ho_gate | output | 1 | High-side gate enable |

## Verification
A phase counter that skips or misses its wrap changes the spacing between `lo_gate` rising edges within the first period, which is at most RUN_PERIOD clocks. A wrong pulse-length setting shows up as an edge that is off by at least one cycle within one period after the next boundary. Config latched mid-period shows up as an edge in the wrong place within the current period. A broken idle/restart path shows up on the first output cycle after enable, because that cycle has either `ho_gate` high or no pulse at all. The scoreboard predicts every output cycle, so any of these faults is reported in the cycle where it first appears.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  typedef enum logic {
    MODE_IGNITE = 1'b0,
    MODE_RUN    = 1'b1
  } hbp_mode_e;

  // Minimum high-side on-time: one tenth of the period, rounded up.
  function automatic int hbp_floor(input int per);
    return (per + 9) / 10;
  endfunction

  // Dead time, kept to at least one clock and small enough to leave room for the floor.
  function automatic int hbp_dead(input int per, input int req);
    int lim;
    lim = per / 2 - hbp_floor(per);
    if (req < 1)   return 1;
    if (req > lim) return lim;
    return req;
  endfunction

  // High-side on-time: half period minus dead time minus the larger reduction, then floored.
  function automatic int hbp_ho(input int per, input int dt, input int trim, input int cut);
    int red;
    int v;
    red = (trim > cut) ? trim : cut;
    v   = per / 2 - dt - red;
    if (v < hbp_floor(per)) v = hbp_floor(per);
    return v;
  endfunction

endpackage

// File: rtl/hbp_cfg_calc.sv
module hbp_cfg_calc
  import hbp_pkg::*;
#(
  parameter int IGN_PERIOD = 40,
  parameter int RUN_PERIOD = 80,
  parameter int DT_W       = 6,
  parameter int TRIM_W     = 7,
  parameter int CNT_W      = 7
) (
  input  logic              sel_run,
  input  logic [DT_W-1:0]   dead_req,
  input  logic [TRIM_W-1:0] trim_req,
  input  logic [TRIM_W-1:0] cut_req,
  output logic [CNT_W-1:0]  per_o,
  output logic [CNT_W-1:0]  dt_o,
  output logic [CNT_W-1:0]  ho_o,
  output logic [CNT_W-1:0]  lo_o
);

  hbp_mode_e mode;
  int        per_i;
  int        dt_i;
  int        ho_i;
  int        lo_i;

  assign mode = hbp_mode_e'(sel_run);

  always_comb begin
    per_i = (mode == MODE_RUN) ? RUN_PERIOD : IGN_PERIOD;
    dt_i  = hbp_dead(per_i, int'(dead_req));
    ho_i  = hbp_ho(per_i, dt_i, int'(trim_req), int'(cut_req));
    lo_i  = per_i - 2 * dt_i - ho_i;
  end

  assign per_o = CNT_W'(per_i);
  assign dt_o  = CNT_W'(dt_i);
  assign ho_o  = CNT_W'(ho_i);
  assign lo_o  = CNT_W'(lo_i);

endmodule

// File: rtl/hbp_phase_ctr.sv
module hbp_phase_ctr #(
  parameter int IGN_PERIOD = 40,
  parameter int RUN_PERIOD = 80,
  parameter int CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_en,
  input  logic [CNT_W-1:0] per_in,
  input  logic [CNT_W-1:0] dt_in,
  input  logic [CNT_W-1:0] ho_in,
  input  logic [CNT_W-1:0] lo_in,
  output logic             run_q,
  output logic             wrap,
  output logic [CNT_W-1:0] phase,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] dt_q,
  output logic [CNT_W-1:0] ho_q,
  output logic [CNT_W-1:0] lo_q
);

  logic load_cfg;

  assign wrap     = (phase == per_q - CNT_W'(1));
  assign load_cfg = !run_q || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      phase <= '0;
      per_q <= '0;
      dt_q  <= '0;
      ho_q  <= '0;
      lo_q  <= '0;
    end else begin
      run_q <= gate_en;
      if (load_cfg) begin
        phase <= '0;
        per_q <= per_in;
        dt_q  <= dt_in;
        ho_q  <= ho_in;
        lo_q  <= lo_in;
      end else begin
        phase <= phase + CNT_W'(1);
      end
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (phase < per_q));  // R1
  AST_PERIOD_SEL: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (int'(per_q) == IGN_PERIOD || int'(per_q) == RUN_PERIOD));  // R1
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase != '0) |-> ($stable(per_q) && $stable(dt_q) && $stable(ho_q) && $stable(lo_q)));  // R9
  AST_CFG_SUM: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (int'(lo_q) + 2 * int'(dt_q) + int'(ho_q) == int'(per_q)));  // R4
  AST_HO_HALF: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (int'(ho_q) + int'(dt_q) <= int'(per_q) / 2));  // R4
  AST_HO_FLOOR: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (int'(ho_q) * 10 >= int'(per_q)));  // R5
  AST_DT_MIN: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (dt_q != '0));  // R3

endmodule

// File: rtl/hbp_out_dec.sv
module hbp_out_dec #(
  parameter int CNT_W = 7
) (
  input  logic             run_q,
  input  logic [CNT_W-1:0] phase,
  input  logic [CNT_W-1:0] dt_q,
  input  logic [CNT_W-1:0] ho_q,
  input  logic [CNT_W-1:0] lo_q,
  output logic             lo_on,
  output logic             ho_on
);

  logic [CNT_W-1:0] ho_start;
  logic [CNT_W-1:0] ho_stop;

  assign ho_start = lo_q + dt_q;
  assign ho_stop  = ho_start + ho_q;

  assign lo_on = run_q && (phase < lo_q);
  assign ho_on = run_q && (phase >= ho_start) && (phase < ho_stop);

endmodule

// File: rtl/hb_pulse_gen.sv
module hb_pulse_gen #(
  parameter int IGN_PERIOD = 40,
  parameter int RUN_PERIOD = 80,
  parameter int DT_W       = 6,
  parameter int TRIM_W     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_run,
  input  logic [DT_W-1:0]   dead_cnt,
  input  logic [TRIM_W-1:0] duty_trim,
  input  logic [TRIM_W-1:0] ss_cut,
  input  logic              gate_en,
  output logic              lo_gate,
  output logic              ho_gate
);

  localparam int CNT_W = $clog2(RUN_PERIOD + 1);

  logic [CNT_W-1:0] per_c, dt_c, ho_c, lo_c;
  logic [CNT_W-1:0] phase, per_q, dt_q, ho_q, lo_q;
  logic             run_q;
  logic             wrap;
  logic             lo_seen;

  hbp_cfg_calc #(
    .IGN_PERIOD(IGN_PERIOD), .RUN_PERIOD(RUN_PERIOD),
    .DT_W(DT_W), .TRIM_W(TRIM_W), .CNT_W(CNT_W)
  ) u_cfg (
    .sel_run (mode_run),
    .dead_req(dead_cnt),
    .trim_req(duty_trim),
    .cut_req (ss_cut),
    .per_o   (per_c),
    .dt_o    (dt_c),
    .ho_o    (ho_c),
    .lo_o    (lo_c)
  );

  hbp_phase_ctr #(
    .IGN_PERIOD(IGN_PERIOD), .RUN_PERIOD(RUN_PERIOD), .CNT_W(CNT_W)
  ) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .gate_en(gate_en),
    .per_in (per_c),
    .dt_in  (dt_c),
    .ho_in  (ho_c),
    .lo_in  (lo_c),
    .run_q  (run_q),
    .wrap   (wrap),
    .phase  (phase),
    .per_q  (per_q),
    .dt_q   (dt_q),
    .ho_q   (ho_q),
    .lo_q   (lo_q)
  );

  hbp_out_dec #(.CNT_W(CNT_W)) u_dec (
    .run_q(run_q),
    .phase(phase),
    .dt_q (dt_q),
    .ho_q (ho_q),
    .lo_q (lo_q),
    .lo_on(lo_gate),
    .ho_on(ho_gate)
  );

  // Low-side pulse observed since the last start; used by the assertions.
  always_ff @(posedge clk) begin
    if (rst || !run_q) lo_seen <= 1'b0;
    else if (lo_gate)  lo_seen <= 1'b1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(lo_gate && ho_gate));  // R8
  AST_GAP_LO_HO: assert property (@(posedge clk) disable iff (rst)
    $past(lo_gate) |-> !ho_gate);  // R8
  AST_GAP_HO_LO: assert property (@(posedge clk) disable iff (rst)
    $past(ho_gate) |-> !lo_gate);  // R8
  AST_LO_FIRST: assert property (@(posedge clk) disable iff (rst)
    ho_gate |-> lo_seen);  // R6
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(gate_en) |-> (!lo_gate && !ho_gate));  // R7
  AST_RESET_LOW: assert property (@(posedge clk)
    $past(rst) |-> (!lo_gate && !ho_gate));  // R10

endmodule

// File: tb/sim_hb_pulse_gen.sv
module sim_hb_pulse_gen;

  localparam int CLK_PERIOD = 10;
  localparam int IGN_P = 40;
  localparam int RUN_P = 80;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_run = 1'b0;
  logic [5:0] dead_cnt = '0;
  logic [6:0] duty_trim = '0;
  logic [6:0] ss_cut = '0;
  logic       gate_en = 1'b0;
  logic       lo_gate, ho_gate;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit    lo;
    bit    ho;
    string tag;
  } exp_t;

  exp_t sb[$];

  // Bench model state
  bit b_run = 1'b0;
  int b_phase = 0;
  int b_per = 0, b_dt = 0, b_ho = 0, b_lo = 0;

  hb_pulse_gen #(.IGN_PERIOD(IGN_P), .RUN_PERIOD(RUN_P), .DT_W(6), .TRIM_W(7)) u0 (
    .clk(clk), .rst(rst), .mode_run(mode_run), .dead_cnt(dead_cnt),
    .duty_trim(duty_trim), .ss_cut(ss_cut), .gate_en(gate_en),
    .lo_gate(lo_gate), .ho_gate(ho_gate)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Settings from the requirements (R3, R4, R5)
  task automatic settle(input bit m, input int dead, input int trim, input int cut);
    int fl, lim, red;
    b_per = m ? RUN_P : IGN_P;
    fl    = b_per / 10 + ((b_per % 10 != 0) ? 1 : 0);
    lim   = b_per / 2 - fl;
    b_dt  = (dead == 0) ? 1 : ((dead > lim) ? lim : dead);
    red   = (cut > trim) ? cut : trim;
    b_ho  = b_per / 2 - b_dt - red;
    if (b_ho < fl) b_ho = fl;
    b_lo  = b_per - 2 * b_dt - b_ho;
  endtask

  // Driver: called at a falling edge; applies inputs and queues n predicted cycles.
  task automatic drive(input bit en, input bit m, input int dead, input int trim,
                       input int cut, input int n, input string tag);
    exp_t e;
    mode_run  = m;
    dead_cnt  = 6'(dead);
    duty_trim = 7'(trim);
    ss_cut    = 7'(cut);
    gate_en   = en;
    @(posedge clk);
    for (int k = 0; k < n; k++) begin
      if (!b_run || b_phase == b_per - 1) begin
        b_phase = 0;
        settle(m, dead, trim, cut);
      end else begin
        b_phase = b_phase + 1;
      end
      b_run = en;
      e.lo  = b_run && (b_phase < b_lo);
      e.ho  = b_run && (b_phase >= b_per - b_dt - b_ho) && (b_phase < b_per - b_dt);
      e.tag = tag;
      sb.push_back(e);
    end
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset(input int cyc);
    rst = 1'b1;
    gate_en = 1'b0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      checks++;
      if (lo_gate || ho_gate) begin
        errors++;
        $display("FAIL R10 reset outputs lo=%0b ho=%0b expected 0 0", lo_gate, ho_gate);
      end
    end
    rst = 1'b0;
    b_run = 1'b0;
    b_phase = 0;
  endtask

  // Monitor: pops predictions and compares; also checks the overlap/gap rule (R8).
  bit prev_lo = 1'b0, prev_ho = 1'b0;
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (lo_gate !== e.lo || ho_gate !== e.ho) begin
        errors++;
        $display("FAIL %s lo/ho actual %0b%0b expected %0b%0b", e.tag, lo_gate, ho_gate, e.lo, e.ho);
      end
    end
    if (!rst) begin
      checks++;
      if ((lo_gate && ho_gate) || (prev_lo && ho_gate) || (prev_ho && lo_gate)) begin
        errors++;
        $display("FAIL R8 lo=%0b ho=%0b prev %0b%0b expected no overlap or adjacency",
                 lo_gate, ho_gate, prev_lo, prev_ho);
      end
    end
    prev_lo = lo_gate;
    prev_ho = ho_gate;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(3);                                        // R10 reset state
    drive(1, 0, 3, 0, 0, 85, "R1 R2 R6 ignition");      // LO first, 17/3/17/3
    drive(1, 1, 3, 0, 0, 170, "R1 R9 switch to run");   // change lands at next boundary
    drive(1, 1, 3, 10, 0, 100, "R4 trim");              // HO 27, LO 47
    drive(1, 1, 3, 3, 20, 100, "R4 soft-start cut");    // HO 17
    drive(1, 1, 3, 100, 0, 100, "R5 floor");            // HO held at 8
    drive(1, 1, 50, 0, 0, 100, "R3 dead clamp high");   // D 32
    drive(1, 1, 0, 0, 0, 100, "R3 dead minimum");       // D 1
    drive(1, 0, 50, 0, 0, 60, "R3 dead clamp ignition");// D 16
    drive(0, 0, 5, 0, 0, 30, "R7 gate off");
    drive(1, 0, 5, 0, 0, 60, "R6 R7 restart");
    drive(1, 1, 5, 37, 0, 30, "R9 mid-period change");
    do_reset(2);                                        // R10 reset mid-run
    drive(1, 1, 4, 0, 0, 90, "R10 R6 restart after reset");
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule